// File: doc/BRIEF.md
# Mesh Node Network Interface (Message Framer and Deframer)

This block connects one SAD processing element to its mesh router and to the shared memory interface. When the element is finished with a 4x4 reference block it hands over the four 32-bit pixel words together with a routing offset and the block id. The block then asks the router for a slot and waits for the router's acknowledge. It then sends a five-flit message: one header flit followed by the four pixel words. Only one outgoing message can be in flight at a time, and a busy flag tells the element when a new one can be accepted.

On the receive side the block watches the flits that the router delivers. It drops the header and gathers the next four data flits into one 128-bit word for the element, which it marks with a single-cycle completion pulse. When the element needs a block that no neighbour holds, it raises a memory request. The block registers the block id and forwards it to the memory interface, tagged with this node's identity so that the reply can be steered back.

Top module: `nif_bridge`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rt_req, rt_flit_vld, pe_tx_busy, pe_rx_done and mi_req are all low.
- R2: A pe_tx_start seen while pe_tx_busy is low makes pe_tx_busy and rt_req high from the next cycle. rt_req then stays high until a cycle in which rt_ack is also high.
- R3: No flit is sent before the acknowledge. In the cycle after rt_req and rt_ack are both high, the header flit is presented, and pixel words 0 to 3 follow on the next four consecutive cycles. rt_flit_vld is high on each of these five cycles and on no other cycle. Pixel word k is pe_tx_pix[32k+31:32k], captured at the accepted start.
- R4: Header flit layout: bits [3:0] hold the X hop count, bits [7:4] the Y hop count, bits [15:8] the block id, and bits [31:16] are zero.
- R5: pe_tx_busy stays high for exactly one more cycle after the last data flit and then falls. A pe_tx_start while pe_tx_busy is high is ignored, and so is rt_ack outside the request phase.
- R6: An incoming flit with rt_in_vld and rt_in_hdr high opens a message. The next four flits with rt_in_vld high and rt_in_hdr low, idle cycles between them allowed, are placed in pe_rx_data with the k-th at bits [32k+31:32k]. pe_rx_done pulses for one cycle, the cycle after the fourth data flit.
- R7: Data flits that arrive with no open message are ignored. A header flit that arrives in the middle of a message discards the partial message and starts a new one.
- R8: pe_mem_req is presented as mi_req one cycle later. mi_blk then carries the block id given with that request, and mi_node carries the NODE_ID parameter (default 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pe_tx_start | input | 1 | Element offers a block to send |
| pe_tx_dx | input | 4 | Signed X hop count |
| pe_tx_dy | input | 4 | Signed Y hop count |
| pe_tx_blk | input | 8 | Reference block id |
| pe_tx_pix | input | 128 | Four pixel words, word 0 in the low bits |
| pe_tx_busy | output | 1 | Outgoing message in progress |
| rt_req | output | 1 | Request to the router |
| rt_ack | input | 1 | Acknowledge from the router |
| rt_flit | output | 32 | Outgoing flit |
| rt_flit_vld | output | 1 | Outgoing flit strobe |
| rt_in_flit | input | 32 | Incoming flit |
| rt_in_vld | input | 1 | Incoming flit strobe |
| rt_in_hdr | input | 1 | Incoming flit is a header |
| pe_rx_data | output | 128 | Received pixel words, word 0 in the low bits |
| pe_rx_done | output | 1 | Received message complete pulse |
| pe_mem_req | input | 1 | Element requests a block from memory |
| pe_mem_blk | input | 8 | Requested block id |
| mi_req | output | 1 | Request to the memory interface |
| mi_blk | output | 8 | Block id to the memory interface |
| mi_node | output | 4 | Requesting node identity |

## Verification
The send path is tried three ways. In the first, the acknowledge is held back for several cycles, which separates a design that waits for it from one that streams early. In the second, the acknowledge is held high throughout and a start is sent during the message, which shows whether stray acknowledges and starts are ignored. In the third, start is held high with changing pixel data, which shows whether data is captured at acceptance and whether the idle cycle between messages is kept. The receive path gets a clean message, one with idle gaps between flits, data flits with no header, and a header in the middle of a message, so that counting errors, missed restarts and stray captures each show up. Memory requests go out with changing ids to check the one-cycle registration.

// File: rtl/nif_pkg.sv
package nif_pkg;
  typedef enum logic [2:0] {
    TX_IDLE = 3'd0,
    TX_REQ  = 3'd1,
    TX_HDR  = 3'd2,
    TX_DATA = 3'd3,
    TX_DONE = 3'd4
  } tx_state_e;
endpackage

// File: rtl/nif_pack.sv
module nif_pack
  import nif_pkg::*;
#(
  parameter int FLIT_W  = 32,
  parameter int WORDS   = 4,
  parameter int COORD_W = 4,
  parameter int ID_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [COORD_W-1:0]      dx,
  input  logic [COORD_W-1:0]      dy,
  input  logic [ID_W-1:0]         blk,
  input  logic [WORDS*FLIT_W-1:0] pix,
  input  logic                    ack,
  output logic                    req,
  output logic [FLIT_W-1:0]       flit,
  output logic                    flit_vld,
  output logic                    busy
);
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int PAD_W = FLIT_W - 2*COORD_W - ID_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS-1);

  tx_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [FLIT_W-1:0] hdr_q;
  logic [WORDS*FLIT_W-1:0] pix_q;
  logic load_en;

  assign load_en = (state_q == TX_IDLE) && start;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      TX_IDLE: if (start) state_d = TX_REQ;
      TX_REQ:  if (ack) state_d = TX_HDR;
      TX_HDR: begin
        state_d = TX_DATA;
        cnt_d   = '0;
      end
      TX_DATA: begin
        if (cnt_q == LAST) state_d = TX_DONE;
        else cnt_d = cnt_q + 1'b1;
      end
      TX_DONE: state_d = TX_IDLE;
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
      pix_q <= '0;
    end else if (load_en) begin
      hdr_q <= {{PAD_W{1'b0}}, blk, dy, dx};
      pix_q <= pix;
    end
  end

  always_comb begin
    req      = (state_q == TX_REQ);
    busy     = (state_q != TX_IDLE);
    flit_vld = (state_q == TX_HDR) || (state_q == TX_DATA);
    flit     = '0;
    if (state_q == TX_HDR) flit = hdr_q;
    else if (state_q == TX_DATA) flit = pix_q[cnt_q*FLIT_W +: FLIT_W];
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);
  // R3
  no_early_flit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flit_vld) |-> $past(req && ack));
  // R5
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_vld || req) |-> busy);
endmodule

// File: rtl/nif_unpack.sv
module nif_unpack #(
  parameter int FLIT_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [FLIT_W-1:0]       in_flit,
  input  logic                    in_vld,
  input  logic                    in_hdr,
  output logic [WORDS*FLIT_W-1:0] data,
  output logic                    done
);
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS-1);

  logic open_q, open_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic done_d;
  logic take;

  assign take = in_vld && !in_hdr && open_q;

  always_comb begin
    open_d = open_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (in_vld && in_hdr) begin
      open_d = 1'b1;
      cnt_d  = '0;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        open_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      done   <= 1'b0;
    end else begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
      done   <= done_d;
    end
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data[k*FLIT_W +: FLIT_W] <= '0;
      else if (take && (cnt_q == CNT_W'(k))) data[k*FLIT_W +: FLIT_W] <= in_flit;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_vld && !in_hdr));
endmodule

// File: rtl/nif_memreq.sv
module nif_memreq #(
  parameter int ID_W   = 8,
  parameter int NODE_W = 4,
  parameter int NODE_ID = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_in,
  input  logic [ID_W-1:0]   blk_in,
  output logic              req_out,
  output logic [ID_W-1:0]   blk_out,
  output logic [NODE_W-1:0] node_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_out <= 1'b0;
    else        req_out <= req_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blk_out <= '0;
    else if (req_in) blk_out <= blk_in;
  end

  assign node_out = NODE_W'(NODE_ID);

  // R8
  mem_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_out == $past(req_in));
endmodule

// File: rtl/nif_bridge.sv
module nif_bridge #(
  parameter int FLIT_W  = 32,
  parameter int WORDS   = 4,
  parameter int COORD_W = 4,
  parameter int ID_W    = 8,
  parameter int NODE_W  = 4,
  parameter int NODE_ID = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pe_tx_start,
  input  logic [COORD_W-1:0]      pe_tx_dx,
  input  logic [COORD_W-1:0]      pe_tx_dy,
  input  logic [ID_W-1:0]         pe_tx_blk,
  input  logic [WORDS*FLIT_W-1:0] pe_tx_pix,
  output logic                    pe_tx_busy,
  output logic                    rt_req,
  input  logic                    rt_ack,
  output logic [FLIT_W-1:0]       rt_flit,
  output logic                    rt_flit_vld,
  input  logic [FLIT_W-1:0]       rt_in_flit,
  input  logic                    rt_in_vld,
  input  logic                    rt_in_hdr,
  output logic [WORDS*FLIT_W-1:0] pe_rx_data,
  output logic                    pe_rx_done,
  input  logic                    pe_mem_req,
  input  logic [ID_W-1:0]         pe_mem_blk,
  output logic                    mi_req,
  output logic [ID_W-1:0]         mi_blk,
  output logic [NODE_W-1:0]       mi_node
);
  nif_pack #(.FLIT_W(FLIT_W), .WORDS(WORDS), .COORD_W(COORD_W), .ID_W(ID_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .start(pe_tx_start), .dx(pe_tx_dx), .dy(pe_tx_dy),
    .blk(pe_tx_blk), .pix(pe_tx_pix), .ack(rt_ack), .req(rt_req), .flit(rt_flit),
    .flit_vld(rt_flit_vld), .busy(pe_tx_busy)
  );

  nif_unpack #(.FLIT_W(FLIT_W), .WORDS(WORDS)) u_unpack (
    .clk(clk), .rst_n(rst_n), .in_flit(rt_in_flit), .in_vld(rt_in_vld),
    .in_hdr(rt_in_hdr), .data(pe_rx_data), .done(pe_rx_done)
  );

  nif_memreq #(.ID_W(ID_W), .NODE_W(NODE_W), .NODE_ID(NODE_ID)) u_mem (
    .clk(clk), .rst_n(rst_n), .req_in(pe_mem_req), .blk_in(pe_mem_blk),
    .req_out(mi_req), .blk_out(mi_blk), .node_out(mi_node)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |->
    !(rt_req || rt_flit_vld || pe_tx_busy || pe_rx_done || mi_req));
endmodule

// File: tb/nif_bridge_tb.sv
module nif_bridge_tb;
  logic clk, rst_n;
  logic pe_tx_start, rt_ack, rt_in_vld, rt_in_hdr, pe_mem_req;
  logic [3:0] pe_tx_dx, pe_tx_dy;
  logic [7:0] pe_tx_blk, pe_mem_blk;
  logic [127:0] pe_tx_pix;
  logic [31:0] rt_in_flit;
  logic pe_tx_busy, rt_req, rt_flit_vld, pe_rx_done, mi_req;
  logic [31:0] rt_flit;
  logic [127:0] pe_rx_data;
  logic [7:0] mi_blk;
  logic [3:0] mi_node;

  nif_bridge u_dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int vectors = 0, errors = 0;
  bit finished = 0;

  // behavioural reference model
  logic [31:0] q_out[$];
  logic [31:0] msg[$];
  bit m_req = 0, m_tail = 0;
  bit m_open = 0, m_done = 0;
  int m_cnt = 0;
  logic [31:0] m_words [4];
  bit m_mreq = 0;
  logic [7:0] m_mblk = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_out.delete(); msg.delete();
      m_req = 0; m_tail = 0; m_open = 0; m_done = 0; m_cnt = 0;
      m_mreq = 0; m_mblk = 0;
      for (int i = 0; i < 4; i++) m_words[i] = 0;
    end else begin
      bit was_busy;
      was_busy = m_req || (q_out.size() > 0) || m_tail;
      m_tail = 0;
      if (q_out.size() > 0) begin
        void'(q_out.pop_front());
        if (q_out.size() == 0) m_tail = 1;
      end
      if (m_req && rt_ack) begin
        m_req = 0;
        q_out = msg;
      end
      if (!was_busy && pe_tx_start) begin
        m_req = 1;
        msg.delete();
        msg.push_back({16'h0, pe_tx_blk, pe_tx_dy, pe_tx_dx});
        for (int i = 0; i < 4; i++) msg.push_back(pe_tx_pix[i*32 +: 32]);
      end
      m_done = 0;
      if (rt_in_vld && rt_in_hdr) begin
        m_open = 1; m_cnt = 0;
      end else if (rt_in_vld && m_open) begin
        m_words[m_cnt] = rt_in_flit;
        m_cnt++;
        if (m_cnt == 4) begin m_done = 1; m_open = 0; m_cnt = 0; end
      end
      m_mreq = pe_mem_req;
      if (pe_mem_req) m_mblk = pe_mem_blk;
    end
  end

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    bit eb;
    eb = m_req || (q_out.size() > 0) || m_tail;
    chk("R1/R2 rt_req", rt_req, m_req);
    chk("R5 pe_tx_busy", pe_tx_busy, eb);
    chk("R3 rt_flit_vld", rt_flit_vld, q_out.size() > 0);
    if (q_out.size() > 0) chk("R3/R4 rt_flit", rt_flit, q_out[0]);
    chk("R6/R7 pe_rx_done", pe_rx_done, m_done);
    if (m_done) chk("R6 pe_rx_data", pe_rx_data,
                    {m_words[3], m_words[2], m_words[1], m_words[0]});
    chk("R8 mi_req", mi_req, m_mreq);
    if (m_mreq) begin
      chk("R8 mi_blk", mi_blk, m_mblk);
      chk("R8 mi_node", mi_node, 4'd5);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic rx(logic hdr, logic [31:0] f);
    rt_in_vld = 1; rt_in_hdr = hdr; rt_in_flit = f;
    cyc(1);
    rt_in_vld = 0; rt_in_hdr = 0;
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pe_tx_start = 0; rt_ack = 0; rt_in_vld = 0; rt_in_hdr = 0;
    pe_mem_req = 0; pe_tx_dx = 4'h3; pe_tx_dy = 4'hE; pe_tx_blk = 8'h5A;
    pe_mem_blk = 0; rt_in_flit = 0;
    pe_tx_pix = 128'h44444444_33333333_22222222_11111111;
    cyc(3);
    rst_n = 1;
    cyc(2);
    // R2 R3: delayed acknowledge
    pe_tx_start = 1; cyc(1); pe_tx_start = 0;
    pe_tx_pix = '1;
    cyc(5);
    rt_ack = 1; cyc(1); rt_ack = 0;
    cyc(8);
    // R5: ack held high, second start during message is ignored
    rt_ack = 1;
    pe_tx_blk = 8'hC3; pe_tx_dx = 4'h8; pe_tx_dy = 4'h1;
    pe_tx_pix = 128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D;
    pe_tx_start = 1; cyc(1); pe_tx_start = 0;
    cyc(3);
    pe_tx_start = 1; pe_tx_blk = 8'h77; cyc(1); pe_tx_start = 0;
    cyc(10);
    // back-to-back with changing data
    pe_tx_start = 1;
    for (int i = 0; i < 24; i++) begin
      pe_tx_pix = {4{32'h1000_0000 + 32'(i)}} ^ 128'h0F;
      pe_tx_blk = 8'(i * 7);
      cyc(1);
    end
    pe_tx_start = 0; rt_ack = 0;
    cyc(10);
    // R6: clean message, then one with gaps
    rx(1, 32'hAAAA0001);
    for (int i = 0; i < 4; i++) rx(0, 32'hB0000000 + 32'(i));
    cyc(3);
    rx(1, 32'h0);
    for (int i = 0; i < 4; i++) begin rx(0, 32'hC1C10000 + 32'(i)); cyc(2); end
    cyc(3);
    // R7: stray data, then header restart mid-message
    for (int i = 0; i < 5; i++) rx(0, 32'hE0E0E0E0 + 32'(i));
    rx(1, 32'h1);
    rx(0, 32'h11111111); rx(0, 32'h22222222);
    rx(1, 32'h2);
    for (int i = 0; i < 4; i++) rx(0, 32'hF00D0000 + 32'(i));
    cyc(4);
    // R8: memory requests
    for (int i = 0; i < 6; i++) begin
      pe_mem_req = (i != 3); pe_mem_blk = 8'(8'h20 + i * 3);
      cyc(1);
    end
    pe_mem_req = 0;
    cyc(5);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule